// File: doc/BRIEF.md
# Small-Triangle Quad Rasterizer

This block takes one screen-space triangle per handshake, given as three vertex positions in unsigned fixed point with four fractional bits. It first sorts the triangle by size. A small triangle is covered right here: the block takes the integer pixel bounding box, rounds its start down to even coordinates, and steps through it one 2x2 quad per cycle. A large triangle is passed on, with no change, to a separate bypass output. That output feeds a conventional rasterizer.

Every pixel sample is tested by itself. The test evaluates the three edge functions straight from the vertex coordinates, so no per-triangle setup values are computed or kept. All arithmetic is exact integer arithmetic on the subpixel grid. A tie-break rule settles which triangle owns a sample that lies exactly on a shared edge, so two triangles that share an edge leave no crack and cover no pixel twice. Quads with at least one covered pixel are sent out with a 4-bit coverage mask. Quads with no covered pixel are skipped. A new triangle is not accepted until every quad of the current one has been sent.

Top module: `utri_raster`

## Requirements
- R1: A triangle is small when two conditions both hold. First, the absolute value of its doubled signed area, counted in 1/256 pixel² units, is below 2*AREA_LIM*256 (so the area is below AREA_LIM = 10 pixels). Second, floor(max/16) - floor(min/16) is below SPAN_LIM = 8 on both the x axis and the y axis. Every other triangle is large.
- R2: A large triangle appears once on the big_* output with its vertices bit-identical and in the same order. It produces no quads.
- R3: Pixel (px,py) is sampled at subpixel point (16*px+8, 16*py+8). The sample is covered when all three edge functions of the edges v0->v1, v1->v2 and v2->v0 are strictly on the interior side. Each edge function is E = (bx-ax)*(py-ay) - (by-ay)*(px-ax), computed exactly. A triangle with zero area covers nothing.
- R4: A sample with E = 0 on some edge is covered only if that edge is an owner edge. An edge is an owner edge when, taken in the interior-positive direction, dy < 0, or dy = 0 and dx > 0. As a result, two triangles that share an edge cover every sample on that edge exactly once.
- R5: Quad origins are even. The columns start at floor(min x/16) with bit 0 cleared and go up while qx <= floor(max x/16). The rows follow the same rule in y. The walk is row by row: x ascends within a row, and the rows ascend.
- R6: quad_mask bit 0 is pixel (qx,qy), bit 1 is (qx+1,qy), bit 2 is (qx,qy+1) and bit 3 is (qx+1,qy+1). A quad is sent when any one of its bits is set.
- R7: A quad with no covered pixel is never sent.
- R8: quad_* and big_* hold valid and data stable while ready is low. tri_ready stays low while a triangle is being worked on.
- R9: Coverage does not depend on winding. Swapping two vertices gives the same quads.
- R10: After reset, tri_ready is high and both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tri_valid | input | 1 | Triangle offered |
| tri_ready | output | 1 | Block idle, triangle accepted |
| tri_x0 | input | 16 | Vertex 0 x, 12.4 fixed point |
| tri_y0 | input | 16 | Vertex 0 y |
| tri_x1 | input | 16 | Vertex 1 x |
| tri_y1 | input | 16 | Vertex 1 y |
| tri_x2 | input | 16 | Vertex 2 x |
| tri_y2 | input | 16 | Vertex 2 y |
| quad_valid | output | 1 | Quad available |
| quad_ready | input | 1 | Quad consumer ready |
| quad_x | output | 12 | Quad origin pixel x (even) |
| quad_y | output | 12 | Quad origin pixel y (even) |
| quad_mask | output | 4 | Coverage, bit order per R6 |
| big_valid | output | 1 | Large triangle available |
| big_ready | input | 1 | Large-triangle consumer ready |
| big_x0 | output | 16 | Forwarded vertex 0 x |
| big_y0 | output | 16 | Forwarded vertex 0 y |
| big_x1 | output | 16 | Forwarded vertex 1 x |
| big_y1 | output | 16 | Forwarded vertex 1 y |
| big_x2 | output | 16 | Forwarded vertex 2 x |
| big_y2 | output | 16 | Forwarded vertex 2 y |

## Verification
The bench goes after several corner cases:
- A square split along a diagonal that runs through pixel centres, plus a triangle whose horizontal edge lies on a sample row. A wrong tie rule would either drop those samples or cover them with both halves.
- A long, thin sliver with a tiny area. A size test that looks only at area would accept it and then walk a large box.
- A diagonal sliver whose box holds empty quads. A design that does not suppress them would send all-zero masks.
- Reversed windings, and collinear vertices. A sign slip would mirror the coverage, or would cover samples on a line of zero area.

Random backpressure on both outputs shows whether data is held stable while ready is low.

// File: rtl/utri_pkg.sv
package utri_pkg;
  parameter int COORD_W = 16;
  parameter int FRAC_W  = 4;
  localparam int PIX_W  = COORD_W - FRAC_W;
  localparam int DIFF_W = COORD_W + 1;
  localparam int EDGE_W = 2 * DIFF_W + 1;

  typedef logic [COORD_W-1:0]       coord_t;
  typedef logic [PIX_W-1:0]         pix_t;
  typedef logic signed [DIFF_W-1:0] diff_t;
  typedef logic signed [EDGE_W-1:0] edge_t;

  typedef struct packed {
    coord_t x0; coord_t y0;
    coord_t x1; coord_t y1;
    coord_t x2; coord_t y2;
  } tri_t;

  // signed difference a-b of two unsigned coordinates
  function automatic diff_t sdiff(coord_t a, coord_t b);
    return $signed({1'b0, a}) - $signed({1'b0, b});
  endfunction

  function automatic edge_t widen(diff_t v);
    return edge_t'(v);
  endfunction

  // exact edge function of directed edge a->b evaluated at p
  function automatic edge_t edge_val(coord_t ax, coord_t ay, coord_t bx,
                                     coord_t by, coord_t px, coord_t py);
    return widen(sdiff(bx, ax)) * widen(sdiff(py, ay))
         - widen(sdiff(by, ay)) * widen(sdiff(px, ax));
  endfunction

  // tie ownership for an edge walked in interior-positive direction
  function automatic logic edge_owner(diff_t dx, diff_t dy);
    return (dy < 0) || ((dy == 0) && (dx > 0));
  endfunction

  function automatic logic edge_pass(edge_t e, logic owner);
    return (e > 0) || ((e == 0) && owner);
  endfunction

  function automatic coord_t pix_centre(pix_t p);
    return {p, 1'b1, {(FRAC_W-1){1'b0}}};
  endfunction

  function automatic coord_t min3(coord_t a, coord_t b, coord_t c);
    coord_t m;
    m = (a < b) ? a : b;
    return (c < m) ? c : m;
  endfunction

  function automatic coord_t max3(coord_t a, coord_t b, coord_t c);
    coord_t m;
    m = (a > b) ? a : b;
    return (c > m) ? c : m;
  endfunction

  // doubled signed area, positive when interior lies on E>0 side
  function automatic edge_t twice_area(tri_t t);
    return edge_val(t.x0, t.y0, t.x1, t.y1, t.x2, t.y2);
  endfunction

  // setup-free coverage test of one sample; flip swaps v1/v2
  function automatic logic sample_covered(tri_t t, logic flip,
                                          coord_t px, coord_t py);
    coord_t ax, ay, bx, by, cx, cy;
    logic p0, p1, p2;
    ax = t.x0; ay = t.y0;
    bx = flip ? t.x2 : t.x1;  by = flip ? t.y2 : t.y1;
    cx = flip ? t.x1 : t.x2;  cy = flip ? t.y1 : t.y2;
    p0 = edge_pass(edge_val(ax, ay, bx, by, px, py),
                   edge_owner(sdiff(bx, ax), sdiff(by, ay)));
    p1 = edge_pass(edge_val(bx, by, cx, cy, px, py),
                   edge_owner(sdiff(cx, bx), sdiff(cy, by)));
    p2 = edge_pass(edge_val(cx, cy, ax, ay, px, py),
                   edge_owner(sdiff(ax, cx), sdiff(ay, cy)));
    return p0 && p1 && p2;
  endfunction
endpackage

// File: rtl/utri_classify.sv
module utri_classify
  import utri_pkg::*;
#(
  parameter int AREA_LIM = 10,
  parameter int SPAN_LIM = 8
) (
  input  tri_t tri_in,
  output logic micro,
  output logic flip,
  output logic degen,
  output pix_t box_x_lo,
  output pix_t box_x_hi,
  output pix_t box_y_lo,
  output pix_t box_y_hi
);
  localparam int    AREA_UNITS = 1 << (2 * FRAC_W);
  localparam edge_t AREA2_LIM  = edge_t'(2 * AREA_LIM * AREA_UNITS);

  edge_t  area2, area2_abs;
  coord_t xmin, xmax, ymin, ymax;
  pix_t   pxmin, pxmax, pymin, pymax;
  logic   small_area, small_span;

  always_comb begin
    area2     = twice_area(tri_in);
    area2_abs = (area2 < 0) ? -area2 : area2;
    xmin = min3(tri_in.x0, tri_in.x1, tri_in.x2);
    xmax = max3(tri_in.x0, tri_in.x1, tri_in.x2);
    ymin = min3(tri_in.y0, tri_in.y1, tri_in.y2);
    ymax = max3(tri_in.y0, tri_in.y1, tri_in.y2);
    pxmin = xmin[COORD_W-1:FRAC_W];
    pxmax = xmax[COORD_W-1:FRAC_W];
    pymin = ymin[COORD_W-1:FRAC_W];
    pymax = ymax[COORD_W-1:FRAC_W];
    small_area = area2_abs < AREA2_LIM;
    small_span = ((pxmax - pxmin) < pix_t'(SPAN_LIM)) &&
                 ((pymax - pymin) < pix_t'(SPAN_LIM));
    micro    = small_area && small_span;
    flip     = area2 < 0;
    degen    = area2 == 0;
    box_x_lo = {pxmin[PIX_W-1:1], 1'b0};
    box_y_lo = {pymin[PIX_W-1:1], 1'b0};
    box_x_hi = pxmax;
    box_y_hi = pymax;
  end
endmodule

// File: rtl/utri_quad_eval.sv
module utri_quad_eval
  import utri_pkg::*;
#(
  parameter int QUAD_DIM = 2
) (
  input  tri_t tri_q,
  input  logic flip_q,
  input  logic degen_q,
  input  pix_t qx,
  input  pix_t qy,
  output logic [QUAD_DIM*QUAD_DIM-1:0] mask
);
  localparam int LANES = QUAD_DIM * QUAD_DIM;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pix_t   lx, ly;
    coord_t sx, sy;
    always_comb begin
      lx = qx + pix_t'(l % QUAD_DIM);
      ly = qy + pix_t'(l / QUAD_DIM);
      sx = pix_centre(lx);
      sy = pix_centre(ly);
      mask[l] = !degen_q && sample_covered(tri_q, flip_q, sx, sy);
    end
  end
endmodule

// File: rtl/utri_walker.sv
module utri_walker
  import utri_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tri_valid,
  output logic       tri_ready,
  input  tri_t       tri_in,
  input  logic       micro,
  input  logic       flip,
  input  logic       degen,
  input  pix_t       box_x_lo,
  input  pix_t       box_x_hi,
  input  pix_t       box_y_lo,
  input  pix_t       box_y_hi,
  output tri_t       tri_q,
  output logic       flip_q,
  output logic       degen_q,
  output pix_t       qx,
  output pix_t       qy,
  input  logic [3:0] mask,
  output logic       quad_valid,
  input  logic       quad_ready,
  output logic       big_valid,
  input  logic       big_ready
);
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_BIG} state_t;

  state_t state;
  pix_t   x_start, x_end, y_end;
  logic [PIX_W:0] nx, ny;
  logic   accept, row_done, col_done, walk_last;
  logic   quad_fire, quad_skip, quad_step, big_fire;

  always_comb begin
    tri_ready  = state == ST_IDLE;
    accept     = tri_valid && tri_ready;
    quad_valid = (state == ST_WALK) && (mask != 4'b0000);
    quad_fire  = quad_valid && quad_ready;
    quad_skip  = (state == ST_WALK) && (mask == 4'b0000);
    quad_step  = quad_fire || quad_skip;
    big_valid  = state == ST_BIG;
    big_fire   = big_valid && big_ready;
    nx = {1'b0, qx} + (PIX_W+1)'(2);
    ny = {1'b0, qy} + (PIX_W+1)'(2);
    row_done  = nx > {1'b0, x_end};
    col_done  = ny > {1'b0, y_end};
    walk_last = row_done && col_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tri_q   <= '0;
      flip_q  <= 1'b0;
      degen_q <= 1'b0;
      qx      <= '0;
      qy      <= '0;
      x_start <= '0;
      x_end   <= '0;
      y_end   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          tri_q   <= tri_in;
          flip_q  <= flip;
          degen_q <= degen;
          qx      <= box_x_lo;
          qy      <= box_y_lo;
          x_start <= box_x_lo;
          x_end   <= box_x_hi;
          y_end   <= box_y_hi;
          state   <= micro ? ST_WALK : ST_BIG;
        end
        ST_WALK: if (quad_step) begin
          if (walk_last) begin
            state <= ST_IDLE;
          end else if (row_done) begin
            qx <= x_start;
            qy <= ny[PIX_W-1:0];
          end else begin
            qx <= nx[PIX_W-1:0];
          end
        end
        ST_BIG: if (big_fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hold_quad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    quad_valid && !quad_ready |=> quad_valid && $stable(qx) && $stable(qy));
  assert_hold_big_R8: assert property (@(posedge clk) disable iff (!rst_n)
    big_valid && !big_ready |=> big_valid && $stable(tri_q));
  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_valid || big_valid) |-> !tri_ready);
  assert_even_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    quad_valid |-> (qx[0] == 1'b0) && (qy[0] == 1'b0));
  assert_box_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    quad_valid |-> (qx <= x_end) && (qy <= y_end));
  assert_one_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(quad_valid && big_valid));
endmodule

// File: rtl/utri_raster.sv
module utri_raster
  import utri_pkg::*;
#(
  parameter int AREA_LIM = 10,
  parameter int SPAN_LIM = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tri_valid,
  output logic               tri_ready,
  input  logic [COORD_W-1:0] tri_x0,
  input  logic [COORD_W-1:0] tri_y0,
  input  logic [COORD_W-1:0] tri_x1,
  input  logic [COORD_W-1:0] tri_y1,
  input  logic [COORD_W-1:0] tri_x2,
  input  logic [COORD_W-1:0] tri_y2,
  output logic               quad_valid,
  input  logic               quad_ready,
  output logic [PIX_W-1:0]   quad_x,
  output logic [PIX_W-1:0]   quad_y,
  output logic [3:0]         quad_mask,
  output logic               big_valid,
  input  logic               big_ready,
  output logic [COORD_W-1:0] big_x0,
  output logic [COORD_W-1:0] big_y0,
  output logic [COORD_W-1:0] big_x1,
  output logic [COORD_W-1:0] big_y1,
  output logic [COORD_W-1:0] big_x2,
  output logic [COORD_W-1:0] big_y2
);
  tri_t tri_in, tri_q;
  logic micro, flip, degen, flip_q, degen_q;
  pix_t box_x_lo, box_x_hi, box_y_lo, box_y_hi, qx, qy;
  logic [3:0] mask;

  assign tri_in = '{x0: tri_x0, y0: tri_y0, x1: tri_x1,
                    y1: tri_y1, x2: tri_x2, y2: tri_y2};

  utri_classify #(.AREA_LIM(AREA_LIM), .SPAN_LIM(SPAN_LIM)) u_classify (
    .tri_in(tri_in), .micro(micro), .flip(flip), .degen(degen),
    .box_x_lo(box_x_lo), .box_x_hi(box_x_hi),
    .box_y_lo(box_y_lo), .box_y_hi(box_y_hi)
  );

  utri_walker u_walker (
    .clk(clk), .rst_n(rst_n), .tri_valid(tri_valid), .tri_ready(tri_ready),
    .tri_in(tri_in), .micro(micro), .flip(flip), .degen(degen),
    .box_x_lo(box_x_lo), .box_x_hi(box_x_hi),
    .box_y_lo(box_y_lo), .box_y_hi(box_y_hi),
    .tri_q(tri_q), .flip_q(flip_q), .degen_q(degen_q), .qx(qx), .qy(qy),
    .mask(mask), .quad_valid(quad_valid), .quad_ready(quad_ready),
    .big_valid(big_valid), .big_ready(big_ready)
  );

  utri_quad_eval #(.QUAD_DIM(2)) u_eval (
    .tri_q(tri_q), .flip_q(flip_q), .degen_q(degen_q),
    .qx(qx), .qy(qy), .mask(mask)
  );

  assign quad_x    = qx;
  assign quad_y    = qy;
  assign quad_mask = mask;
  assign big_x0 = tri_q.x0;
  assign big_y0 = tri_q.y0;
  assign big_x1 = tri_q.x1;
  assign big_y1 = tri_q.y1;
  assign big_x2 = tri_q.x2;
  assign big_y2 = tri_q.y2;

  assert_no_empty_quad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    quad_valid |-> quad_mask != 4'b0000);
  assert_big_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(big_valid) |-> $past(tri_valid) && $past(tri_ready));
endmodule

// File: tb/utri_raster_bench.sv
module utri_raster_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tri_valid = 1'b0, quad_ready = 1'b0, big_ready = 1'b0;
  logic tri_ready, quad_valid, big_valid;
  logic [15:0] tri_x0 = '0, tri_y0 = '0, tri_x1 = '0, tri_y1 = '0, tri_x2 = '0, tri_y2 = '0;
  logic [15:0] big_x0, big_y0, big_x1, big_y1, big_x2, big_y2;
  logic [11:0] quad_x, quad_y;
  logic [3:0]  quad_mask;

  int checks = 0, errors = 0, cycles = 0;
  bit done_flag = 0;
  int exp_x[64], exp_y[64], exp_m[64], exp_n;
  int got_x[64], got_y[64], got_m[64], got_n, got_big;
  logic [15:0] gb[6];
  int cov[16][16];

  always #10 clk = ~clk;

  utri_raster u_utri_raster (.*);

  function automatic longint ef(longint ax, longint ay, longint bx, longint by,
                                longint px, longint py);
    return (bx - ax) * (py - ay) - (by - ay) * (px - ax);
  endfunction

  function automatic bit owns(longint dx, longint dy);
    return (dy < 0) || (dy == 0 && dx > 0);
  endfunction

  function automatic bit side_ok(longint s, longint e, longint ax, longint ay,
                                 longint bx, longint by);
    if (s > 0) return (e > 0) || (e == 0 && owns(bx - ax, by - ay));
    return (e < 0) || (e == 0 && owns(ax - bx, ay - by));
  endfunction

  function automatic bit covered(longint x0, longint y0, longint x1, longint y1,
                                 longint x2, longint y2, longint px, longint py);
    longint s, cx, cy;
    s = ef(x0, y0, x1, y1, x2, y2);
    if (s == 0) return 0;
    cx = px * 16 + 8;
    cy = py * 16 + 8;
    return side_ok(s, ef(x0, y0, x1, y1, cx, cy), x0, y0, x1, y1) &&
           side_ok(s, ef(x1, y1, x2, y2, cx, cy), x1, y1, x2, y2) &&
           side_ok(s, ef(x2, y2, x0, y0, cx, cy), x2, y2, x0, y0);
  endfunction

  function automatic int mn(int a, int b, int c);
    int m = a; if (b < m) m = b; if (c < m) m = c; return m;
  endfunction
  function automatic int mx(int a, int b, int c);
    int m = a; if (b > m) m = b; if (c > m) m = c; return m;
  endfunction

  function automatic bit is_micro(int x0, int y0, int x1, int y1, int x2, int y2);
    longint a;
    a = ef(x0, y0, x1, y1, x2, y2);
    if (a < 0) a = -a;
    return (a < 5120) && ((mx(x0, x1, x2) / 16 - mn(x0, x1, x2) / 16) < 8) &&
           ((mx(y0, y1, y2) / 16 - mn(y0, y1, y2) / 16) < 8);
  endfunction

  task automatic build_expected(int x0, int y0, int x1, int y1, int x2, int y2);
    int xs, xe, ys, ye, m;
    exp_n = 0;
    if (!is_micro(x0, y0, x1, y1, x2, y2)) return;
    xs = (mn(x0, x1, x2) / 16) & ~1;  xe = mx(x0, x1, x2) / 16;
    ys = (mn(y0, y1, y2) / 16) & ~1;  ye = mx(y0, y1, y2) / 16;
    for (int qy = ys; qy <= ye; qy += 2)
      for (int qx = xs; qx <= xe; qx += 2) begin
        m = 0;
        for (int l = 0; l < 4; l++)
          if (covered(x0, y0, x1, y1, x2, y2, qx + (l % 2), qy + (l / 2))) m |= (1 << l);
        if (m != 0) begin
          exp_x[exp_n] = qx; exp_y[exp_n] = qy; exp_m[exp_n] = m; exp_n++;
        end
      end
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic run_tri(int x0, int y0, int x1, int y1, int x2, int y2, string req);
    bit pend = 0;
    int px = 0, py = 0, pm = 0;
    bit micro;
    micro = is_micro(x0, y0, x1, y1, x2, y2);
    build_expected(x0, y0, x1, y1, x2, y2);
    got_n = 0; got_big = 0;
    @(negedge clk);
    tri_x0 = 16'(x0); tri_y0 = 16'(y0); tri_x1 = 16'(x1);
    tri_y1 = 16'(y1); tri_x2 = 16'(x2); tri_y2 = 16'(y2);
    tri_valid = 1'b1;
    while (!tri_ready) @(negedge clk);
    @(negedge clk);
    tri_valid = 1'b0;
    forever begin
      if (tri_ready) break;
      quad_ready = ($urandom % 4) != 0;
      big_ready  = ($urandom % 3) != 0;
      if (pend)  // R8: held quad must not change
        check(quad_valid && quad_x == 12'(px) && quad_y == 12'(py) && quad_mask == 4'(pm),
              "R8", "held quad changed", int'(quad_x), px);
      if (quad_valid && quad_ready && got_n < 64) begin
        got_x[got_n] = int'(quad_x); got_y[got_n] = int'(quad_y);
        got_m[got_n] = int'(quad_mask); got_n++;
      end
      if (big_valid && big_ready) begin
        got_big++;
        gb[0] = big_x0; gb[1] = big_y0; gb[2] = big_x1;
        gb[3] = big_y1; gb[4] = big_x2; gb[5] = big_y2;
      end
      pend = quad_valid && !quad_ready;
      px = int'(quad_x); py = int'(quad_y); pm = int'(quad_mask);
      @(negedge clk);
    end
    quad_ready = 1'b0; big_ready = 1'b0;
    // R1/R2 path choice and bypass data
    check(got_big == (micro ? 0 : 1), micro ? "R1" : "R2", "big transfers", got_big, micro ? 0 : 1);
    if (!micro)
      check(gb[0] == 16'(x0) && gb[1] == 16'(y0) && gb[2] == 16'(x1) &&
            gb[3] == 16'(y1) && gb[4] == 16'(x2) && gb[5] == 16'(y2),
            "R2", "bypass vertex data", int'(gb[0]), x0);
    check(got_n == exp_n, req, "quad count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_x[i] == exp_x[i] && got_y[i] == exp_y[i], "R5", "quad origin", got_x[i] * 4096 + got_y[i], exp_x[i] * 4096 + exp_y[i]);
      check(got_m[i] == exp_m[i], req, "quad mask", got_m[i], exp_m[i]);
      check(got_m[i] != 0, "R7", "empty quad sent", got_m[i], 1);
    end
  endtask

  task automatic add_cov();
    for (int i = 0; i < got_n; i++)
      for (int l = 0; l < 4; l++)
        if (got_m[i][l] && got_x[i] + l % 2 < 16 && got_y[i] + l / 2 < 16)
          cov[got_x[i] + l % 2][got_y[i] + l / 2]++;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done_flag) begin
        done_flag = 1;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(tri_ready === 1'b1 && quad_valid === 1'b0 && big_valid === 1'b0,
          "R10", "reset outputs", int'({tri_ready, quad_valid, big_valid}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(tri_ready === 1'b1 && quad_valid === 1'b0 && big_valid === 1'b0,
          "R10", "idle after reset", int'({tri_ready, quad_valid, big_valid}), 4);
    // R3/R6: small triangle around one pixel centre
    run_tri(80, 80, 100, 80, 80, 100, "R3");
    // R9: reversed winding gives same coverage
    run_tri(80, 80, 80, 100, 100, 80, "R9");
    run_tri(37, 21, 90, 30, 50, 75, "R6");
    run_tri(37, 21, 50, 75, 90, 30, "R9");
    // R4: square split on a diagonal through sample centres
    for (int i = 0; i < 16; i++) for (int j = 0; j < 16; j++) cov[i][j] = 0;
    run_tri(32, 32, 96, 32, 96, 96, "R4");
    add_cov();
    run_tri(32, 32, 96, 96, 32, 96, "R4");
    add_cov();
    for (int i = 2; i < 6; i++)
      for (int j = 2; j < 6; j++)
        check(cov[i][j] == 1, "R4", "shared-edge coverage count", cov[i][j], 1);
    // R4: horizontal edge on a sample row, both sides
    run_tri(24, 40, 72, 40, 48, 72, "R4");
    run_tri(24, 40, 48, 12, 72, 40, "R4");
    // R1: long sliver of tiny area goes to bypass
    run_tri(0, 0, 160, 16, 160, 17, "R1");
    // R2: large triangle forwarded
    run_tri(0, 0, 320, 0, 0, 320, "R2");
    // R7: diagonal sliver with empty quads in its box
    run_tri(16, 16, 112, 100, 100, 112, "R7");
    // R3: degenerate collinear triangle covers nothing
    run_tri(40, 40, 56, 56, 72, 72, "R3");
    // random mix
    for (int n = 0; n < 300; n++) begin
      int bx, by, rng;
      bx = 16 * ($urandom % 200);
      by = 16 * ($urandom % 200);
      rng = (($urandom % 5) == 0) ? 400 : 110;
      run_tri(bx + $urandom % rng, by + $urandom % rng, bx + $urandom % rng,
              by + $urandom % rng, bx + $urandom % rng, by + $urandom % rng, "R3");
    end
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule